// File: doc/BRIEF.md
# Secure Sector Mode Command Gate

This block qualifies decoded commands for a flash-style memory controller that has a one-time-programmable secure sector overlaid on the normal array. It tracks three things. The first is whether the overlay (secure) mode is active. The second is the program/erase suspend status, which the controller supplies. The third is the protection bit of the secure sector, also supplied as an input. With these it decides, for each command strobe, whether the command may proceed. The answer is a one-cycle grant pulse or a one-cycle reject pulse, one clock after the strobe.

For a granted chip erase, the block also computes the sector mask that the erase engine must apply. The mask has one bit per array sector, and a set bit means the sector is erased. It keeps one boot sector out of the erase, and the boot-configuration input chooses which one. The secure sector has no bit in this mask, so no erase can ever reach it.

Commands arrive as single-cycle strobes with no handshake. The block never applies back-pressure, and every strobe receives a verdict on the next cycle. Unlock-cycle decoding, array timing and the storage cells are handled elsewhere.

Top module: `secure_sector_gate`

## Requirements
- R1: While reset is held and on the first cycle after it, `ss_active`, `cmd_grant`, `cmd_reject` and `erase_go` are 0 and `erase_mask` is all zeros, so the block starts in normal array mode.
- R2: A lone secure-entry strobe is granted on the next cycle and sets `ss_active`. This holds whether or not `suspended` is high.
- R3: A lone secure-exit strobe is granted and clears `ss_active` when the mode is active. When the mode is not active, the strobe is rejected.
- R4: A resume strobe is always rejected while `ss_active` is 1, and stays rejected until an exit is granted. In normal mode a resume is granted when `suspended` is 1 and rejected when it is 0.
- R5: A lone chip-erase strobe is granted in both normal and secure mode when `suspended` is 0, and rejected when `suspended` is 1.
- R6: On a granted chip erase, `erase_go` pulses for one cycle and `erase_mask` (width `N_SECT`, default 46) becomes all ones except one bit. That bit is bit 0 when `boot_top` is 1 and bit `N_SECT-1` (45) when `boot_top` is 0. `erase_mask` then holds until the next granted chip erase.
- R7: A lone program strobe is rejected while `ss_active` and `ss_locked` are both 1. It is granted in secure mode when `ss_locked` is 0, and granted in normal mode.
- R8: When two or more command strobes are high in the same cycle, the command is rejected.
- R9: `cmd_grant` and `cmd_reject` are never high together, and each is a single-cycle pulse per strobe cycle. A reject changes neither `ss_active` nor `erase_mask`. A cycle with no strobe produces neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_ss_entry | input | 1 | Strobe: enter secure-sector mode |
| cmd_ss_exit | input | 1 | Strobe: leave secure-sector mode |
| cmd_resume | input | 1 | Strobe: resume a suspended program/erase |
| cmd_chip_erase | input | 1 | Strobe: chip erase |
| cmd_program | input | 1 | Strobe: program (targets the secure sector while the mode is active) |
| suspended | input | 1 | A program or erase is currently suspended |
| boot_top | input | 1 | 1 = top-boot configuration, 0 = bottom-boot configuration |
| ss_locked | input | 1 | Stored secure-sector protection bit |
| cmd_grant | output | 1 | One-cycle pulse: command accepted |
| cmd_reject | output | 1 | One-cycle pulse: command refused |
| ss_active | output | 1 | Secure-sector mode is active |
| erase_go | output | 1 | One-cycle pulse: a chip erase was granted and `erase_mask` is fresh |
| erase_mask | output | N_SECT | Sectors that the granted chip erase clears |

## Verification
On every cycle, the assertions check the following:
- grant and reject are exclusive;
- a reject leaves the mode flag and the mask untouched;
- a resume is refused while the overlay is active;
- a lone entry is always taken;
- a locked secure program is refused;
- an unsuspended chip erase is taken;
- multi-strobe cycles are refused;
- each fresh erase mask clears exactly one bit, and that bit is at one end of the vector.

Some behaviours only the bench scenarios can show. These are which end of the mask the boot select picks, the resume becoming legal again after an exit, exit being refused outside the mode, and the reset state of a block that was active before reset.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_ENTRY = 3'd1,
    KIND_EXIT  = 3'd2,
    KIND_RSM   = 3'd3,
    KIND_ERASE = 3'd4,
    KIND_PROG  = 3'd5,
    KIND_MULTI = 3'd6
  } cmd_kind_t;

  localparam int unsigned NUM_STROBES = 5;

  // strobe vector bit positions
  localparam int unsigned SB_ENTRY = 0;
  localparam int unsigned SB_EXIT  = 1;
  localparam int unsigned SB_RSM   = 2;
  localparam int unsigned SB_ERASE = 3;
  localparam int unsigned SB_PROG  = 4;

endpackage

// File: rtl/sscg_cmd_decode.sv
module sscg_cmd_decode
  import sscg_pkg::*;
(
  input  logic [NUM_STROBES-1:0] strobes,
  output cmd_kind_t              kind
);

  localparam int unsigned CNT_W = $clog2(NUM_STROBES + 1);

  logic [CNT_W-1:0] hits;

  always_comb begin
    hits = '0;
    for (int i = 0; i < NUM_STROBES; i++) begin
      hits = hits + CNT_W'(strobes[i]);
    end
  end

  always_comb begin
    kind = KIND_NONE;
    if (hits > CNT_W'(1)) begin
      kind = KIND_MULTI;
    end else if (strobes[SB_ENTRY]) begin
      kind = KIND_ENTRY;
    end else if (strobes[SB_EXIT]) begin
      kind = KIND_EXIT;
    end else if (strobes[SB_RSM]) begin
      kind = KIND_RSM;
    end else if (strobes[SB_ERASE]) begin
      kind = KIND_ERASE;
    end else if (strobes[SB_PROG]) begin
      kind = KIND_PROG;
    end
  end

endmodule

// File: rtl/sscg_rule_check.sv
module sscg_rule_check
  import sscg_pkg::*;
(
  input  cmd_kind_t kind,
  input  logic      mode_on,
  input  logic      suspended,
  input  logic      locked,
  output logic      accept,
  output logic      refuse
);

  always_comb begin
    accept = 1'b0;
    refuse = 1'b0;
    unique case (kind)
      KIND_NONE:  ;
      KIND_ENTRY: accept = 1'b1;
      KIND_EXIT:  begin
        accept = mode_on;
        refuse = !mode_on;
      end
      KIND_RSM:   begin
        accept = !mode_on && suspended;
        refuse = mode_on || !suspended;
      end
      KIND_ERASE: begin
        accept = !suspended;
        refuse = suspended;
      end
      KIND_PROG:  begin
        accept = !(mode_on && locked);
        refuse = mode_on && locked;
      end
      KIND_MULTI: refuse = 1'b1;
      default:    refuse = 1'b1;
    endcase
  end

endmodule

// File: rtl/sscg_mask_gen.sv
module sscg_mask_gen #(
  parameter int unsigned N_SECT = 46
) (
  input  logic              boot_top,
  output logic [N_SECT-1:0] mask
);

  localparam int unsigned IDX_W   = (N_SECT > 1) ? $clog2(N_SECT) : 1;
  localparam int unsigned TOP_IDX = 0;
  localparam int unsigned BOT_IDX = N_SECT - 1;

  logic [IDX_W-1:0] keep_idx;

  assign keep_idx = boot_top ? IDX_W'(TOP_IDX) : IDX_W'(BOT_IDX);

  for (genvar g = 0; g < N_SECT; g++) begin : g_bit
    assign mask[g] = (keep_idx != IDX_W'(g));
  end

endmodule

// File: rtl/secure_sector_gate.sv
module secure_sector_gate
  import sscg_pkg::*;
#(
  parameter int unsigned N_SECT = 46
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_ss_entry,
  input  logic              cmd_ss_exit,
  input  logic              cmd_resume,
  input  logic              cmd_chip_erase,
  input  logic              cmd_program,
  input  logic              suspended,
  input  logic              boot_top,
  input  logic              ss_locked,
  output logic              cmd_grant,
  output logic              cmd_reject,
  output logic              ss_active,
  output logic              erase_go,
  output logic [N_SECT-1:0] erase_mask
);

  logic [NUM_STROBES-1:0] strobes;
  cmd_kind_t              kind;
  logic                   accept;
  logic                   refuse;
  logic [N_SECT-1:0]      mask_next;

  always_comb begin
    strobes           = '0;
    strobes[SB_ENTRY] = cmd_ss_entry;
    strobes[SB_EXIT]  = cmd_ss_exit;
    strobes[SB_RSM]   = cmd_resume;
    strobes[SB_ERASE] = cmd_chip_erase;
    strobes[SB_PROG]  = cmd_program;
  end

  sscg_cmd_decode u_decode (
    .strobes (strobes),
    .kind    (kind)
  );

  sscg_rule_check u_rules (
    .kind      (kind),
    .mode_on   (ss_active),
    .suspended (suspended),
    .locked    (ss_locked),
    .accept    (accept),
    .refuse    (refuse)
  );

  sscg_mask_gen #(.N_SECT(N_SECT)) u_mask (
    .boot_top (boot_top),
    .mask     (mask_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_grant  <= 1'b0;
      cmd_reject <= 1'b0;
      ss_active  <= 1'b0;
      erase_go   <= 1'b0;
      erase_mask <= '0;
    end else begin
      cmd_grant  <= accept;
      cmd_reject <= refuse;
      erase_go   <= accept && (kind == KIND_ERASE);
      if (accept && kind == KIND_ENTRY) begin
        ss_active <= 1'b1;
      end else if (accept && kind == KIND_EXIT) begin
        ss_active <= 1'b0;
      end
      if (accept && kind == KIND_ERASE) begin
        erase_mask <= mask_next;
      end
    end
  end

  AST_GRANT_REJECT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_grant && cmd_reject)); // R9

  AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> ($stable(ss_active) && $stable(erase_mask) && !erase_go)); // R9

  AST_ENTRY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(strobes) == 1 && cmd_ss_entry) |=> (cmd_grant && ss_active)); // R2

  AST_RESUME_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_resume && ss_active) |=> (cmd_reject && !cmd_grant)); // R4

  AST_ERASE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(strobes) == 1 && cmd_chip_erase && !suspended) |=> (cmd_grant && erase_go)); // R5

  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> ($countones(erase_mask) == N_SECT - 1 &&
                  erase_mask[0] != erase_mask[N_SECT-1])); // R6

  AST_LOCKED_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(strobes) == 1 && cmd_program && ss_active && ss_locked) |=> cmd_reject); // R7

  AST_MULTI_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(strobes) > 1) |=> (cmd_reject && !cmd_grant)); // R8

endmodule

// File: tb/secure_sector_gate_tb_top.sv
module secure_sector_gate_tb_top;

  localparam int unsigned N_SECT = 46;
  localparam time         TCLK   = 10ns;
  localparam int unsigned NVEC   = 18;

  // {entry,exit,resume,erase,prog,susp,top,locked, grant,reject,active,go}
  localparam logic [11:0] VEC [NVEC] = '{
    12'b00000000_0000, // idle              R9
    12'b01000000_0100, // exit, normal      R3
    12'b00100000_0100, // resume, no susp   R4
    12'b00100100_1000, // resume, susp      R4
    12'b00010010_1001, // erase top         R5 R6
    12'b00010100_0100, // erase, susp       R5
    12'b00001000_1000, // program normal    R7
    12'b10000100_1010, // entry while susp  R2
    12'b00100100_0110, // resume in mode    R4
    12'b00010000_1011, // erase bottom      R5 R6
    12'b00001001_0110, // program locked    R7
    12'b00001000_1010, // program unlocked  R7
    12'b11000000_0110, // entry+exit        R8
    12'b01000000_1000, // exit in mode      R3
    12'b00100100_1000, // resume after exit R4
    12'b00011000_0100, // erase+program     R8
    12'b10000000_1010, // entry             R2
    12'b00000000_0010  // idle              R9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_ss_entry = 1'b0, cmd_ss_exit = 1'b0, cmd_resume = 1'b0;
  logic cmd_chip_erase = 1'b0, cmd_program = 1'b0;
  logic suspended = 1'b0, boot_top = 1'b0, ss_locked = 1'b0;
  logic cmd_grant, cmd_reject, ss_active, erase_go;
  logic [N_SECT-1:0] erase_mask;

  int unsigned total = 0;
  int unsigned bad   = 0;
  logic        finished = 1'b0;
  logic [N_SECT-1:0] mask_ref = '0;

  always #(TCLK/2) clk = ~clk;

  secure_sector_gate #(.N_SECT(N_SECT)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_ss_entry   (cmd_ss_entry),
    .cmd_ss_exit    (cmd_ss_exit),
    .cmd_resume     (cmd_resume),
    .cmd_chip_erase (cmd_chip_erase),
    .cmd_program    (cmd_program),
    .suspended      (suspended),
    .boot_top       (boot_top),
    .ss_locked      (ss_locked),
    .cmd_grant      (cmd_grant),
    .cmd_reject     (cmd_reject),
    .ss_active      (ss_active),
    .erase_go       (erase_go),
    .erase_mask     (erase_mask)
  );

  function automatic logic [N_SECT-1:0] want_mask(input logic top);
    logic [N_SECT-1:0] m;
    m = '1;
    if (top) m[0] = 1'b0;
    else     m[N_SECT-1] = 1'b0;
    return m;
  endfunction

  task automatic check(input string req, input logic [N_SECT-1:0] act,
                       input logic [N_SECT-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] s);
    {cmd_ss_entry, cmd_ss_exit, cmd_resume, cmd_chip_erase, cmd_program,
     suspended, boot_top, ss_locked} = s;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset flags", N_SECT'({cmd_grant, cmd_reject, ss_active, erase_go}), '0);
    check("R1 reset mask", erase_mask, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first cycle flags", N_SECT'({cmd_grant, cmd_reject, ss_active, erase_go}), '0);

    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v][11:4]);
      @(negedge clk);
      drive(8'h00);
      check($sformatf("R2-9 vector %0d flags", v),
            N_SECT'({cmd_grant, cmd_reject, ss_active, erase_go}),
            N_SECT'(VEC[v][3:0]));
      if (VEC[v][0]) mask_ref = want_mask(VEC[v][5]);
      check($sformatf("R6 vector %0d mask", v), erase_mask, mask_ref);
    end

    // R9: a reject pulse lasts one cycle
    drive(8'b01000000); // exit in mode -> grant, leaves mode
    @(negedge clk);
    drive(8'b01000000); // exit in normal mode -> reject
    @(negedge clk);
    drive(8'h00);
    check("R9 reject pulse", N_SECT'({cmd_grant, cmd_reject}), N_SECT'(2'b01));
    @(negedge clk);
    check("R9 reject cleared", N_SECT'({cmd_grant, cmd_reject}), '0);

    // R6: bottom-boot erase skips sector 45, and the mask holds afterwards
    drive(8'b00010000);
    @(negedge clk);
    drive(8'h00);
    check("R6 bottom mask", erase_mask, want_mask(1'b0));
    check("R6 bottom bit 45 kept", N_SECT'(erase_mask[N_SECT-1]), '0);
    @(negedge clk);
    check("R6 go one cycle", N_SECT'(erase_go), '0);
    check("R6 mask held", erase_mask, want_mask(1'b0));

    // R1: reset from secure mode returns to normal mode
    drive(8'b10000000);
    @(negedge clk);
    drive(8'h00);
    check("R2 entry before reset", N_SECT'(ss_active), N_SECT'(1));
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset leaves mode", N_SECT'(ss_active), '0);
    check("R1 reset clears mask", erase_mask, '0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule